// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the write port of a NOR-style flash device. It turns bus write cycles, each an address and a data word, into operation requests for the internal program/erase controller. A valid instruction starts with two fixed unlock writes. The third write is a setup command. Program takes a fourth write that carries the target address and data. Block and chip erase take a second unlock pair and then a confirm write. If a write breaks the expected sequence, the decoder abandons the sequence, returns reads to array data and starts nothing.

Each accepted instruction raises one request strobe for one clock. The strobe appears on the clock edge that samples the final write of the instruction. Program and erase requests carry a latched address, and program requests also carry a latched data word. The decoder tracks the read mode, which is either array data or signature/protection data after auto-select. It also tracks whether an erase is running or suspended, so that it can route suspend and resume. A busy level and a one-cycle done pulse from the controller close the loop.

The sequencer has seven states:
- `ST_IDLE` waits for the first unlock write.
- `ST_UNLK1` waits for the second unlock write.
- `ST_UNLK2` waits for the setup command.
- `ST_PROG_ARG` waits for the program address and data.
- `ST_ERS_UNLK1` and `ST_ERS_UNLK2` wait for the repeated unlock pair.
- `ST_ERS_CONF` waits for the erase confirm.

The sequencer follows these transitions:
- `ST_IDLE` goes to `ST_UNLK1` on the first unlock write.
- `ST_UNLK1` goes to `ST_UNLK2` on the second unlock write.
- `ST_UNLK2` goes to `ST_PROG_ARG` on the program setup.
- `ST_UNLK2` goes to `ST_ERS_UNLK1` on the erase setup.
- `ST_UNLK2` goes back to `ST_IDLE` on auto-select or read/reset, and raises the matching strobe.
- `ST_PROG_ARG` goes to `ST_IDLE` on any write, and raises the program strobe.
- `ST_ERS_UNLK1` goes to `ST_ERS_UNLK2`, then to `ST_ERS_CONF`, on the repeated unlock writes.
- `ST_ERS_CONF` goes to `ST_IDLE` on any write, and raises block erase, raises chip erase or aborts.
- Any unexpected write goes to `ST_IDLE` as an abort.
- Lockout goes to `ST_IDLE` from any state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, or in the cycle after `lockout` is high, `read_sig` is 0 and no strobe is raised. A partly entered sequence is discarded, so the next write must again be a first unlock write.
- R2: Only the low 11 address bits are decoded. The first unlock write is data 0xAA at 0x555. The second unlock write is data 0x55 at 0x2AA. The setup write must be at 0x555. Upper address bits are ignored.
- R3: A setup of 0xF0 raises `req_read_array` and sets `read_sig` to 0. A setup of 0x90 raises `req_autoselect` and sets `read_sig` to 1.
- R4: After the 0xA0 setup, the next write raises `req_program`. `req_addr` and `req_data` then carry that write's address and data. No strobe is raised on the first three writes.
- R5: After the 0x80 setup and a second unlock pair, the confirm write decides the result. Data 0x30 raises `req_block_erase`, with `req_addr` set to the confirm address. Data 0x10 at 0x555 raises `req_chip_erase`. No strobe is raised on the first five writes.
- R6: A write that does not match the expected cycle raises no strobe, sets `read_sig` to 0 and returns the sequence to its start.
- R7: Strobes last one cycle. At most one strobe is high at a time. A strobe is high only in the cycle after a sampled write.
- R8: While `ctl_busy` is 1, writes change no state and raise no strobe, with the single exception given in R9.
- R9: A write of data 0xB0 while `ctl_busy` is 1 and an erase is running and not suspended raises `req_suspend`. In any other situation the write raises no suspend.
- R10: While an erase is suspended and `ctl_busy` is 0, a write of data 0x30 at the start of a sequence raises `req_resume`. The erase setup is refused while suspended. A `ctl_done` pulse during suspension does not end the erase.
- R11: Raising `req_program`, `req_block_erase` or `req_chip_erase` sets `read_sig` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout | input | 1 | Supply lockout; forces read-array mode |
| wr_en | input | 1 | Bus write cycle present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; commands use bits 7:0 |
| ctl_busy | input | 1 | Controller is running an operation |
| ctl_done | input | 1 | One-cycle pulse when an operation completes |
| req_read_array | output | 1 | Read/reset request strobe |
| req_autoselect | output | 1 | Auto-select request strobe |
| req_program | output | 1 | Program request strobe |
| req_block_erase | output | 1 | Block erase request strobe |
| req_chip_erase | output | 1 | Chip erase request strobe |
| req_suspend | output | 1 | Erase suspend request strobe |
| req_resume | output | 1 | Erase resume request strobe |
| req_addr | output | ADDR_W | Address latched with program or erase |
| req_data | output | DATA_W | Data latched with program |
| read_sig | output | 1 | 1 = reads return signature/protection data |

## Verification
The bench drives complete instructions of every kind, so that each request can be told apart from the others. It drives sequences that break at each cycle position: wrong data, wrong address, and a confirm that is wrong for the chosen erase type. These show that an abort is taken at that position and not a request. Unlock writes with upper address bits set show that only the low bits are decoded. The same sequences are repeated with the controller busy, with and without a running erase, and inside a suspension. These separate the busy gate, suspend routing, the refused erase setup, and resume after a program run inside the suspension.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CODE_UNLK1    = 8'hAA;
    localparam logic [7:0] CODE_UNLK2    = 8'h55;
    localparam logic [7:0] CODE_PROG     = 8'hA0;
    localparam logic [7:0] CODE_ERASE    = 8'h80;
    localparam logic [7:0] CODE_ASEL     = 8'h90;
    localparam logic [7:0] CODE_RESET    = 8'hF0;
    localparam logic [7:0] CODE_BLK_CONF = 8'h30;
    localparam logic [7:0] CODE_CHIP     = 8'h10;
    localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
    localparam logic [7:0] CODE_RESUME   = 8'h30;

    localparam int NUM_STRB = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PROG_ARG,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_ERS_CONF
    } seq_state_t;

    // Value n (1..7) maps to strobe bit n-1.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ_ARRAY,
        OP_AUTOSEL,
        OP_PROGRAM,
        OP_BLK_ERASE,
        OP_CHIP_ERASE,
        OP_SUSPEND,
        OP_RESUME
    } op_t;

    typedef struct packed {
        logic unlk1;
        logic unlk2;
        logic at_cmd;
        logic prog;
        logic erase;
        logic asel;
        logic reset;
        logic blk;
        logic chip;
        logic susp;
        logic resume;
    } hit_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int UNLK_W = 11
) (
    input  logic [UNLK_W-1:0] addr,
    input  logic [7:0]        data,
    output hit_t              hit
);

    localparam logic [UNLK_W-1:0] ADDR_A = UNLK_W'(12'h555);
    localparam logic [UNLK_W-1:0] ADDR_B = UNLK_W'(12'h2AA);

    logic at_a;
    logic at_b;

    always_comb begin
        at_a       = (addr == ADDR_A);
        at_b       = (addr == ADDR_B);
        hit.unlk1  = at_a && (data == CODE_UNLK1);
        hit.unlk2  = at_b && (data == CODE_UNLK2);
        hit.at_cmd = at_a;
        hit.prog   = (data == CODE_PROG);
        hit.erase  = (data == CODE_ERASE);
        hit.asel   = (data == CODE_ASEL);
        hit.reset  = (data == CODE_RESET);
        hit.blk    = (data == CODE_BLK_CONF);
        hit.chip   = (data == CODE_CHIP);
        hit.susp   = (data == CODE_SUSPEND);
        hit.resume = (data == CODE_RESUME);
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lockout,
    input  logic wr_en,
    input  logic ctl_busy,
    input  hit_t hit,
    input  logic ers_active,
    input  logic suspended,
    output op_t  op_d,
    output logic abort
);

    seq_state_t st_q;
    seq_state_t st_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state, requested operation and abort.
    always_comb begin
        st_d  = st_q;
        op_d  = OP_NONE;
        abort = 1'b0;
        if (lockout) begin
            st_d = ST_IDLE;
        end else if (wr_en && ctl_busy) begin
            if (hit.susp && ers_active && !suspended) op_d = OP_SUSPEND;
        end else if (wr_en) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (hit.unlk1)                   st_d = ST_UNLK1;
                    else if (hit.resume && suspended) op_d = OP_RESUME;
                    else                              abort = 1'b1;
                end
                ST_UNLK1: begin
                    if (hit.unlk2) st_d = ST_UNLK2;
                    else begin
                        st_d  = ST_IDLE;
                        abort = 1'b1;
                    end
                end
                ST_UNLK2: begin
                    st_d = ST_IDLE;
                    if (!hit.at_cmd)                  abort = 1'b1;
                    else if (hit.prog)                st_d = ST_PROG_ARG;
                    else if (hit.erase && !suspended) st_d = ST_ERS_UNLK1;
                    else if (hit.asel)                op_d = OP_AUTOSEL;
                    else if (hit.reset)               op_d = OP_READ_ARRAY;
                    else                              abort = 1'b1;
                end
                ST_PROG_ARG: begin
                    st_d = ST_IDLE;
                    op_d = OP_PROGRAM;
                end
                ST_ERS_UNLK1: begin
                    if (hit.unlk1) st_d = ST_ERS_UNLK2;
                    else begin
                        st_d  = ST_IDLE;
                        abort = 1'b1;
                    end
                end
                ST_ERS_UNLK2: begin
                    if (hit.unlk2) st_d = ST_ERS_CONF;
                    else begin
                        st_d  = ST_IDLE;
                        abort = 1'b1;
                    end
                end
                ST_ERS_CONF: begin
                    st_d = ST_IDLE;
                    if (hit.blk)                     op_d = OP_BLK_ERASE;
                    else if (hit.chip && hit.at_cmd) op_d = OP_CHIP_ERASE;
                    else                             abort = 1'b1;
                end
                default: begin
                    st_d  = ST_IDLE;
                    abort = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_track.sv
module flash_cmd_track
    import flash_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lockout,
    input  op_t  op_d,
    input  logic abort,
    input  logic ctl_done,
    output logic ers_active,
    output logic suspended,
    output logic read_sig
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ers_active <= 1'b0;
            suspended  <= 1'b0;
        end else if (lockout) begin
            ers_active <= 1'b0;
            suspended  <= 1'b0;
        end else begin
            if (op_d == OP_BLK_ERASE || op_d == OP_CHIP_ERASE)
                ers_active <= 1'b1;
            else if (ctl_done && !suspended)
                ers_active <= 1'b0;
            if (op_d == OP_SUSPEND)     suspended <= 1'b1;
            else if (op_d == OP_RESUME) suspended <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 read_sig <= 1'b0;
        else if (lockout || abort)  read_sig <= 1'b0;
        else begin
            unique case (op_d)
                OP_AUTOSEL:    read_sig <= 1'b1;
                OP_READ_ARRAY,
                OP_PROGRAM,
                OP_BLK_ERASE,
                OP_CHIP_ERASE: read_sig <= 1'b0;
                default:       read_sig <= read_sig;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_issue.sv
module flash_cmd_issue
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  op_t                 op_d,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_STRB-1:0] strb,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_data
);

    logic [NUM_STRB-1:0] strb_d;
    logic                latch_addr;

    for (genvar i = 0; i < NUM_STRB; i++) begin : g_strb
        assign strb_d[i] = (op_d == op_t'(3'(i + 1)));
    end

    assign latch_addr = strb_d[2] || strb_d[3] || strb_d[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb     <= '0;
            req_addr <= '0;
            req_data <= '0;
        end else begin
            strb <= strb_d;
            if (latch_addr) req_addr <= wr_addr;
            if (strb_d[2])  req_data <= wr_data;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int UNLK_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lockout,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctl_busy,
    input  logic              ctl_done,
    output logic              req_read_array,
    output logic              req_autoselect,
    output logic              req_program,
    output logic              req_block_erase,
    output logic              req_chip_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              read_sig
);

    hit_t                hit;
    op_t                 op_d;
    logic                abort;
    logic                ers_active;
    logic                suspended;
    logic [NUM_STRB-1:0] strb;

    flash_cmd_match #(.UNLK_W(UNLK_W)) u_match (
        .addr (wr_addr[UNLK_W-1:0]),
        .data (wr_data[7:0]),
        .hit  (hit)
    );

    flash_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lockout    (lockout),
        .wr_en      (wr_en),
        .ctl_busy   (ctl_busy),
        .hit        (hit),
        .ers_active (ers_active),
        .suspended  (suspended),
        .op_d       (op_d),
        .abort      (abort)
    );

    flash_cmd_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .lockout    (lockout),
        .op_d       (op_d),
        .abort      (abort),
        .ctl_done   (ctl_done),
        .ers_active (ers_active),
        .suspended  (suspended),
        .read_sig   (read_sig)
    );

    flash_cmd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_d     (op_d),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .strb     (strb),
        .req_addr (req_addr),
        .req_data (req_data)
    );

    assign req_read_array  = strb[0];
    assign req_autoselect  = strb[1];
    assign req_program     = strb[2];
    assign req_block_erase = strb[3];
    assign req_chip_erase  = strb[4];
    assign req_suspend     = strb[5];
    assign req_resume      = strb[6];

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic lockout,
    input logic wr_en,
    input logic ctl_busy,
    input logic req_read_array,
    input logic req_autoselect,
    input logic req_program,
    input logic req_block_erase,
    input logic req_chip_erase,
    input logic req_suspend,
    input logic req_resume,
    input logic read_sig
);

    logic [6:0] s;
    assign s = {req_resume, req_suspend, req_chip_erase, req_block_erase,
                req_program, req_autoselect, req_read_array};

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s));

    p_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (s == 7'd0));

    p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (s == 7'd0) && !read_sig);

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy |=> (s[6] == 1'b0) && (s[4:0] == 5'd0));

    p_suspend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_suspend |-> $past(ctl_busy));

    p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume |-> !$past(ctl_busy));

    p_asel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_autoselect |-> read_sig);

    p_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_program || req_block_erase || req_chip_erase) |-> !read_sig);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lockout         (lockout),
    .wr_en           (wr_en),
    .ctl_busy        (ctl_busy),
    .req_read_array  (req_read_array),
    .req_autoselect  (req_autoselect),
    .req_program     (req_program),
    .req_block_erase (req_block_erase),
    .req_chip_erase  (req_chip_erase),
    .req_suspend     (req_suspend),
    .req_resume      (req_resume),
    .read_sig        (read_sig)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam logic [6:0] SB_NO = 7'h00;
    localparam logic [6:0] SB_RA = 7'h01;
    localparam logic [6:0] SB_AS = 7'h02;
    localparam logic [6:0] SB_PG = 7'h04;
    localparam logic [6:0] SB_BE = 7'h08;
    localparam logic [6:0] SB_CE = 7'h10;
    localparam logic [6:0] SB_SU = 7'h20;
    localparam logic [6:0] SB_RS = 7'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lockout = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          ctl_busy = 1'b0;
    logic          ctl_done = 1'b0;
    logic          req_read_array, req_autoselect, req_program;
    logic          req_block_erase, req_chip_erase, req_suspend, req_resume;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          read_sig;
    logic [6:0]    strb;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .lockout(lockout), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ctl_busy(ctl_busy),
        .ctl_done(ctl_done), .req_read_array(req_read_array),
        .req_autoselect(req_autoselect), .req_program(req_program),
        .req_block_erase(req_block_erase), .req_chip_erase(req_chip_erase),
        .req_suspend(req_suspend), .req_resume(req_resume),
        .req_addr(req_addr), .req_data(req_data), .read_sig(read_sig)
    );

    assign strb = {req_resume, req_suspend, req_chip_erase, req_block_erase,
                   req_program, req_autoselect, req_read_array};

    task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One write cycle, then check the strobes at the following negedge.
    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [6:0] exp,
                      string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        expect_eq(tag, 32'(strb), 32'(exp));
    endtask

    task automatic unlock(string tag);
        wr(16'h0555, 16'h00AA, SB_NO, tag);
        wr(16'h02AA, 16'h0055, SB_NO, tag);
    endtask

    task automatic finish_op();
        @(negedge clk); ctl_busy = 1'b0; ctl_done = 1'b1;
        @(negedge clk); ctl_done = 1'b0;
    endtask

    task automatic t_reset();
        expect_eq("R1 reset strobes", 32'(strb), 32'(SB_NO));
        expect_eq("R1 reset read_sig", 32'(read_sig), 0);
    endtask

    task automatic t_setup_modes();
        unlock("R2 unlock");
        wr(16'h0555, 16'h0090, SB_AS, "R3 autoselect strobe");
        expect_eq("R3 read_sig set", 32'(read_sig), 1);
        unlock("R2 unlock");
        wr(16'h0555, 16'h00F0, SB_RA, "R3 read-array strobe");
        expect_eq("R3 read_sig clear", 32'(read_sig), 0);
    endtask

    task automatic t_program();
        unlock("R2 unlock");
        wr(16'h0555, 16'h0090, SB_AS, "R3 autoselect");
        unlock("R4 early");
        wr(16'h0555, 16'h00A0, SB_NO, "R4 setup no strobe");
        wr(16'h4321, 16'h1234, SB_PG, "R4 program strobe");
        expect_eq("R4 req_addr", 32'(req_addr), 32'h4321);
        expect_eq("R4 req_data", 32'(req_data), 32'h1234);
        expect_eq("R11 program clears read_sig", 32'(read_sig), 0);
        @(negedge clk);
        expect_eq("R7 one-cycle strobe", 32'(strb), 32'(SB_NO));
        finish_op();
    endtask

    task automatic t_erase();
        unlock("R5 early");
        wr(16'h0555, 16'h0080, SB_NO, "R5 setup");
        unlock("R5 second pair");
        wr(16'h7000, 16'h0030, SB_BE, "R5 block erase");
        expect_eq("R5 block addr", 32'(req_addr), 32'h7000);
        finish_op();
        unlock("R5 early");
        wr(16'h0555, 16'h0080, SB_NO, "R5 setup");
        unlock("R5 second pair");
        wr(16'h0555, 16'h0010, SB_CE, "R5 chip erase");
        finish_op();
    endtask

    task automatic t_bad();
        unlock("R2 unlock");
        wr(16'h0555, 16'h0090, SB_AS, "R3 autoselect");
        wr(16'h0555, 16'h00AA, SB_NO, "R6 first");
        wr(16'h02AB, 16'h0055, SB_NO, "R6 wrong address second");
        expect_eq("R6 abort clears read_sig", 32'(read_sig), 0);
        wr(16'h0555, 16'h00A0, SB_NO, "R6 sequence restarted");
        wr(16'h1111, 16'h2222, SB_NO, "R6 no program after abort");
        wr(16'h0556, 16'h00AA, SB_NO, "R2 wrong first address");
        wr(16'h02AA, 16'h0055, SB_NO, "R2 stray second");
        unlock("R6 erase break");
        wr(16'h0555, 16'h0080, SB_NO, "R6 setup");
        wr(16'h0555, 16'h00AA, SB_NO, "R6 fourth");
        wr(16'h02AA, 16'h0054, SB_NO, "R6 wrong fifth data");
        wr(16'h0100, 16'h0030, SB_NO, "R6 confirm after abort");
        unlock("R6 chip confirm");
        wr(16'h0555, 16'h0080, SB_NO, "R6 setup");
        unlock("R6 pair");
        wr(16'h0554, 16'h0010, SB_NO, "R6 chip confirm wrong address");
        unlock("R6 bad setup");
        wr(16'h0555, 16'h0077, SB_NO, "R6 unknown setup");
        wr(16'hF555, 16'h00AA, SB_NO, "R2 high bits first");
        wr(16'h12AA, 16'h0055, SB_NO, "R2 high bits second");
        wr(16'h8555, 16'h00A0, SB_NO, "R2 high bits setup");
        wr(16'h0042, 16'h00BE, SB_PG, "R2 upper bits ignored");
        finish_op();
    endtask

    task automatic t_busy();
        @(negedge clk); ctl_busy = 1'b1;
        unlock("R8 busy unlock");
        wr(16'h0555, 16'h00A0, SB_NO, "R8 busy setup");
        wr(16'h0033, 16'h0044, SB_NO, "R8 busy program ignored");
        wr(16'h0000, 16'h00B0, SB_NO, "R9 suspend without erase");
        finish_op();
        wr(16'h0033, 16'h0044, SB_NO, "R8 state unchanged");
    endtask

    task automatic t_suspend();
        unlock("R9 erase");
        wr(16'h0555, 16'h0080, SB_NO, "R9 setup");
        unlock("R9 pair");
        wr(16'h3000, 16'h0030, SB_BE, "R9 erase start");
        @(negedge clk); ctl_busy = 1'b1;
        wr(16'h0000, 16'h00B0, SB_SU, "R9 suspend");
        @(negedge clk); ctl_busy = 1'b0;
        unlock("R10 erase setup");
        wr(16'h0555, 16'h0080, SB_NO, "R10 erase refused");
        unlock("R10 after refusal");
        wr(16'h0555, 16'h0010, SB_NO, "R10 not a setup");
        unlock("R10 program in suspend");
        wr(16'h0555, 16'h00A0, SB_NO, "R10 setup");
        wr(16'h0200, 16'h5A5A, SB_PG, "R10 program in suspend");
        @(negedge clk); ctl_busy = 1'b1;
        finish_op();
        wr(16'h0000, 16'h0030, SB_RS, "R10 resume");
        @(negedge clk); ctl_busy = 1'b1;
        wr(16'h0000, 16'h00B0, SB_SU, "R10 erase kept across done");
        @(negedge clk); ctl_busy = 1'b0;
        wr(16'h0000, 16'h0030, SB_RS, "R10 resume again");
        @(negedge clk); ctl_busy = 1'b1;
        finish_op();
        @(negedge clk); ctl_busy = 1'b1;
        wr(16'h0000, 16'h00B0, SB_NO, "R9 suspend after erase done");
        @(negedge clk); ctl_busy = 1'b0;
        wr(16'h0000, 16'h0030, SB_NO, "R10 resume when not suspended");
    endtask

    task automatic t_lockout();
        unlock("R1 unlock");
        wr(16'h0555, 16'h0090, SB_AS, "R3 autoselect");
        unlock("R1 partial");
        @(negedge clk); lockout = 1'b1;
        @(negedge clk); lockout = 1'b0;
        expect_eq("R1 lockout read_sig", 32'(read_sig), 0);
        wr(16'h0555, 16'h00A0, SB_NO, "R1 sequence discarded");
        wr(16'h0001, 16'h0002, SB_NO, "R1 no program");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup_modes();
        t_program();
        t_erase();
        t_bad();
        t_busy();
        t_suspend();
        t_lockout();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule